// File: doc/BRIEF.md
# Double-Precision Round and Pack Unit

This block turns an unpacked floating-point result into a packed IEEE 754 binary64 word and the exception causes that go with it. The unpacked value arrives as a sign, a signed unbiased exponent and a 56-bit significand. The significand holds the leading one at bit 55, the 52 fraction bits below it, and three guard bits at the bottom. Upstream arithmetic (add, multiply, divide, convert) must deliver the significand already normalised, with bit 55 set. This block then does the rest. It denormalises tiny values with sticky collection and rounds in one of four modes. It renormalises on a rounding carry, saturates on overflow and, if asked, flushes tiny results.

Overflow results and flush results both depend on the rounding direction and on the sign. A value one binade below the smallest normal exponent takes a special path: when rounding would carry it back into the normal range, it is packed as the smallest normal number and only inexact is raised. The result and the three cause flags are registered and appear one clock after the inputs.

Top module: `dpk_round_pack`

## Requirements
- R1: The result word and the cause flags (inexact, underflow, overflow) are registered. They reflect the inputs of the previous rising clock edge. While reset is asserted they are all zero.
- R2: Take an input with exponent e in [-1022, 1023] and guard bits sig[2:0] equal to zero. It is packed with sign at bit 63 and biased exponent e+1023 in bits 62:52. Bits 51:0 hold sig[54:3], the leading bit is dropped, and no flag is raised.
- R3: The rounding mode is 2 bits: 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity. Rounding applies only when the guard bits are nonzero, and then inexact is set. Mode 0 adds 3 plus significand bit 3. Mode 1 adds nothing. Mode 2 adds 8 to positive values only, and mode 3 adds 8 to negative values only.
- R4: A rounding carry out of bit 55 shifts the significand right by one and raises the exponent by one.
- R5: When the final exponent exceeds 1023, overflow and inexact are set. Each mode returns a fixed value. Mode 0 returns a signed infinity (exponent field 0x7FF, fraction 0). Mode 1 returns the signed largest finite value (0x7FE, all-ones fraction). Mode 2 returns +infinity or the largest finite negative value. Mode 3 returns the largest finite positive value or -infinity.
- R6: When the exponent is below -1022 and flush is off, the significand is shifted right by (-1022 - e). Every bit shifted out is ORed into bit 0. A shift of 56 or more leaves exactly 1. A result without the leading bit is packed with exponent field 0. Underflow is set when such a value is inexact.
- R7: Consider an exponent of exactly -1023 with flush off, where rounding the unshifted significand carries out of bit 55. The result is then the signed smallest normal value (exponent field 1, fraction 0), with inexact set and underflow clear.
- R8: When the exponent is below -1022 and flush is on, underflow and inexact are set. Modes 0 and 1 return a zero of the input sign. Mode 2 returns the smallest positive subnormal for positive inputs and -0 for negative ones. Mode 3 returns +0 for positive inputs and the smallest negative subnormal for negative ones.
- R9: A result packed with exponent field 0 also raises underflow whenever the underflow trap-enable input is high, even if exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sign_i | input | 1 | Sign of the unpacked value |
| exp_i | input | 13 | Signed unbiased exponent |
| sig_i | input | 56 | Significand, leading one at bit 55, guard bits 2:0 |
| rmode_i | input | 2 | Rounding mode (0 nearest, 1 zero, 2 up, 3 down) |
| flush_i | input | 1 | Flush tiny results instead of denormalising |
| uf_trap_i | input | 1 | Underflow trap enable |
| res_o | output | 64 | Packed binary64 result |
| inexact_o | output | 1 | Inexact cause |
| underflow_o | output | 1 | Underflow cause |
| overflow_o | output | 1 | Overflow cause |

## Verification
The bench targets three groups of cases.

- Rounding ties at both parities of bit 3. A design that rounds ties away from zero would return an odd fraction where an even one is due.
- The all-ones significand, which carries into a new binade. Without renormalisation the exponent would be one too low and the fraction wrong. At exponent 1023 the same carry must become an overflow with the mode-specific saturation value, and a swapped up/down sign test would show up there.
- The tiny range:
  - exponent -1023 with a carry, where a design without the special path raises a spurious underflow;
  - shifts far past the significand width, where a missing clamp loses the sticky bit and rounds up to zero or drops the smallest subnormal;
  - exact subnormals with the trap enable set;
  - every flush mode/sign pair.

// File: rtl/dpk_pkg.sv
package dpk_pkg;
  parameter int SIG_W  = 56;   // significand incl. leading one and guard bits
  parameter int FRAC_W = 52;   // packed fraction field
  parameter int EXPF_W = 11;   // packed exponent field
  parameter int GRD_W  = 3;    // guard bits below the fraction
  parameter int BIAS   = 1023;
  parameter int EMIN   = -1022;
  parameter int EMAX   = 1023;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;
endpackage

// File: rtl/dpk_round_inc.sv
// Adds the mode-dependent rounding increment; result is one bit wider.
module dpk_round_inc
  import dpk_pkg::*;
#(
  parameter int W = SIG_W
) (
  input  logic         sign,
  input  rmode_e       mode,
  input  logic [W-1:0] m,
  output logic [W:0]   r
);
  logic [W:0] inc;

  always_comb begin
    inc = '0;
    if (|m[GRD_W-1:0]) begin
      unique case (mode)
        RM_NEAR: inc = (W+1)'(3) + (W+1)'(m[GRD_W]);
        RM_ZERO: inc = '0;
        RM_UP:   inc = sign ? '0 : (W+1)'(8);
        RM_DOWN: inc = sign ? (W+1)'(8) : '0;
        default: inc = '0;
      endcase
    end
    r = {1'b0, m} + inc;
  end
endmodule

// File: rtl/dpk_sticky_shift.sv
// Right shift with every discarded bit ORed into bit 0; clamps wide shifts.
module dpk_sticky_shift #(
  parameter int W   = 56,
  parameter int SHW = 15
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   dout
);
  logic [W-1:0] lost_mask;
  logic         sticky;

  always_comb begin
    lost_mask = ~({W{1'b1}} << amt);
    sticky    = |(din & lost_mask);
    if (amt >= SHW'(W)) begin
      dout = {{(W-1){1'b0}}, |din};
    end else begin
      dout = (din >> amt) | {{(W-1){1'b0}}, sticky};
    end
  end
endmodule

// File: rtl/dpk_limit_val.sv
// Saturation word for overflow (ovf=1) or flush-to-zero (ovf=0).
module dpk_limit_val
  import dpk_pkg::*;
#(
  parameter int WORD_W = 1 + EXPF_W + FRAC_W
) (
  input  logic              sign,
  input  rmode_e            mode,
  input  logic              ovf,
  output logic [WORD_W-1:0] val
);
  logic away;   // mode rounds this sign away from zero

  always_comb begin
    away = ((mode == RM_UP) && !sign) || ((mode == RM_DOWN) && sign);
    if (ovf) begin
      if (away || (mode == RM_NEAR)) begin
        val = {sign, {EXPF_W{1'b1}}, {FRAC_W{1'b0}}};
      end else begin
        val = {sign, {(EXPF_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
      end
    end else begin
      val = {sign, {(EXPF_W+FRAC_W-1){1'b0}}, away};
    end
  end
endmodule

// File: rtl/dpk_round_pack.sv
module dpk_round_pack
  import dpk_pkg::*;
#(
  parameter int EXP_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic [1:0]       rmode_i,
  input  logic             flush_i,
  input  logic             uf_trap_i,
  output logic [63:0]      res_o,
  output logic             inexact_o,
  output logic             underflow_o,
  output logic             overflow_o
);
  localparam int XW     = EXP_W + 2;
  localparam int WORD_W = 1 + EXPF_W + FRAC_W;
  localparam logic signed [XW-1:0] EMIN_X   = XW'(EMIN);
  localparam logic signed [XW-1:0] EMINM1_X = XW'(EMIN - 1);
  localparam logic signed [XW-1:0] EMAX_X   = XW'(EMAX);
  localparam logic signed [XW-1:0] BIAS_X   = XW'(BIAS);

  // reset: asserted asynchronously, released on the clock
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  rmode_e mode;
  assign mode = rmode_e'(rmode_i);

  logic signed [XW-1:0] e_in;
  logic                 tiny, near_edge, early_carry, flush_hit;
  logic [XW-1:0]        shamt;
  logic [SIG_W:0]       rnd_raw;
  logic [SIG_W-1:0]     shifted;

  assign e_in      = XW'($signed(exp_i));
  assign tiny      = e_in < EMIN_X;
  assign near_edge = e_in == EMINM1_X;
  assign shamt     = EMIN_X - e_in;
  assign flush_hit = tiny && flush_i;

  dpk_round_inc #(.W(SIG_W)) u_rnd_pre (
    .sign (sign_i), .mode (mode), .m (sig_i), .r (rnd_raw)
  );

  dpk_sticky_shift #(.W(SIG_W), .SHW(XW)) u_shift (
    .din (sig_i), .amt (shamt), .dout (shifted)
  );

  assign early_carry = near_edge && rnd_raw[SIG_W];

  // stage 1: denormalise or take the carry path
  logic [SIG_W-1:0]     m1;
  logic signed [XW-1:0] e1;
  logic                 lost1, uf1;

  always_comb begin
    if (early_carry) begin
      m1 = {rnd_raw[SIG_W:GRD_W+1], {GRD_W{1'b0}}};
    end else if (tiny) begin
      m1 = shifted;
    end else begin
      m1 = sig_i;
    end
    e1    = tiny ? EMIN_X : e_in;
    lost1 = |m1[GRD_W-1:0];
    uf1   = lost1 && !m1[SIG_W-1];
  end

  // stage 2: round, renormalise
  logic [SIG_W:0]       rnd_fin;
  logic [SIG_W-1:0]     m2;
  logic signed [XW-1:0] e2, e_biased;
  logic [FRAC_W:0]      mant;
  logic                 ovf;

  dpk_round_inc #(.W(SIG_W)) u_rnd_fin (
    .sign (sign_i), .mode (mode), .m (m1), .r (rnd_fin)
  );

  always_comb begin
    m2       = rnd_fin[SIG_W] ? rnd_fin[SIG_W:1] : rnd_fin[SIG_W-1:0];
    e2       = e1 + (rnd_fin[SIG_W] ? XW'(1) : XW'(0));
    mant     = m2[SIG_W-1:GRD_W];
    e_biased = e2 + BIAS_X;
    ovf      = e2 > EMAX_X;
  end

  logic [WORD_W-1:0] ovf_word, flush_word;

  dpk_limit_val u_lim_ovf (
    .sign (sign_i), .mode (mode), .ovf (1'b1), .val (ovf_word)
  );
  dpk_limit_val u_lim_flush (
    .sign (sign_i), .mode (mode), .ovf (1'b0), .val (flush_word)
  );

  logic unused_bits;
  assign unused_bits = ^{m2[GRD_W-1:0], rnd_raw[GRD_W:0], e_biased[XW-1:EXPF_W]};

  // next state
  logic [63:0] res_d;
  logic        ix_d, uf_d, ov_d;

  always_comb begin
    ov_d = 1'b0;
    if (flush_hit) begin
      res_d = flush_word;
      ix_d  = 1'b1;
      uf_d  = 1'b1;
    end else if (ovf) begin
      res_d = ovf_word;
      ix_d  = 1'b1;
      uf_d  = 1'b0;
      ov_d  = 1'b1;
    end else if (!mant[FRAC_W]) begin
      res_d = {sign_i, {EXPF_W{1'b0}}, mant[FRAC_W-1:0]};
      ix_d  = lost1 || early_carry;
      uf_d  = uf1 || uf_trap_i;
    end else begin
      res_d = {sign_i, e_biased[EXPF_W-1:0], mant[FRAC_W-1:0]};
      ix_d  = lost1 || early_carry;
      uf_d  = uf1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      res_o       <= '0;
      inexact_o   <= 1'b0;
      underflow_o <= 1'b0;
      overflow_o  <= 1'b0;
    end else begin
      res_o       <= res_d;
      inexact_o   <= ix_d;
      underflow_o <= uf_d;
      overflow_o  <= ov_d;
    end
  end

  AST_OVF_INEXACT: assert property (@(posedge clk) disable iff (!rst_s)
    overflow_o |-> inexact_o); // R5
  AST_RZ_FINITE: assert property (@(posedge clk) disable iff (!rst_s)
    (rmode_i == 2'd1) |=> (res_o[62:52] != 11'h7FF)); // R5
  AST_EXACT_NORMAL: assert property (@(posedge clk) disable iff (!rst_s)
    (!tiny && e_in < EMAX_X && sig_i[2:0] == 3'b000)
      |=> (!inexact_o && !underflow_o && !overflow_o)); // R2
  AST_FLUSH_TINY: assert property (@(posedge clk) disable iff (!rst_s)
    (flush_i && tiny) |=> (underflow_o && inexact_o && res_o[62:1] == '0)); // R8
  AST_EDGE_CARRY: assert property (@(posedge clk) disable iff (!rst_s)
    (near_edge && !flush_i && rmode_i == 2'd0 && (&sig_i))
      |=> (res_o[62:52] == 11'd1 && res_o[51:0] == '0 && !underflow_o)); // R7
endmodule

// File: tb/test_dpk_round_pack.sv
`timescale 1ns/1ps
module test_dpk_round_pack;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sign_i;
  logic [12:0] exp_i;
  logic [55:0] sig_i;
  logic [1:0]  rmode_i;
  logic        flush_i, uf_trap_i;
  logic [63:0] res_o;
  logic        inexact_o, underflow_o, overflow_o;

  always #2 clk = ~clk;   // 250 MHz

  dpk_round_pack i_dpk_round_pack (
    .clk (clk), .rst_n (rst_n), .sign_i (sign_i), .exp_i (exp_i),
    .sig_i (sig_i), .rmode_i (rmode_i), .flush_i (flush_i),
    .uf_trap_i (uf_trap_i), .res_o (res_o), .inexact_o (inexact_o),
    .underflow_o (underflow_o), .overflow_o (overflow_o)
  );

  typedef struct {
    logic [63:0] r;
    logic        ix, uf, ov;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   finished = 0;

  function automatic logic [56:0] bump(bit sn, logic [56:0] m, logic [1:0] rm);
    longint unsigned add = 0;
    if (m[2:0] != 0) begin
      if (rm == 2'd0) add = 3 + m[3];
      else if (rm == 2'd2 && !sn) add = 8;
      else if (rm == 2'd3 && sn) add = 8;
    end
    return m + 57'(add);
  endfunction

  // behavioural model written from the requirements
  function automatic exp_t model(bit sn, int e, logic [55:0] s, logic [1:0] rm,
                                 bit fl, bit tr);
    exp_t o;
    logic [56:0] m, t;
    int ex, sh;
    bit away;
    o.r = 0; o.ix = 0; o.uf = 0; o.ov = 0; o.tag = "R2";
    away = (rm == 2'd2 && !sn) || (rm == 2'd3 && sn);
    m = {1'b0, s};
    ex = e;
    if (ex < -1022) begin
      if (fl) begin
        o.ix = 1; o.uf = 1; o.tag = "R8";
        o.r = {sn, 62'd0, away};
        return o;
      end
      t = bump(sn, m, rm);
      if (ex == -1023 && t[56]) begin
        o.ix = 1; o.tag = "R7";
        m = (t >> 1) & ~57'h7;
      end else begin
        o.tag = "R6";
        sh = -1022 - ex;
        if (sh >= 56) m = 57'd1;
        else m = (m >> sh) | 57'((m & ((57'd1 << sh) - 57'd1)) != 0);
      end
      ex = -1022;
    end
    if (m[2:0] != 0) begin
      o.ix = 1;
      if (o.tag == "R2") o.tag = "R3";
      if (!m[55]) o.uf = 1;
      m = bump(sn, m, rm);
      if (m[56]) begin m = m >> 1; ex = ex + 1; if (o.tag == "R3") o.tag = "R4"; end
    end
    m = m >> 3;
    if (ex > 1023) begin
      o.ov = 1; o.ix = 1; o.uf = 0; o.tag = "R5";
      if (rm == 2'd0 || away) o.r = {sn, 11'h7FF, 52'd0};
      else o.r = {sn, 11'h7FE, {52{1'b1}}};
      return o;
    end
    if (!m[52]) begin
      if (tr) begin o.uf = 1; o.tag = "R9"; end
      o.r = {sn, 11'd0, m[51:0]};
    end else begin
      o.r = {sn, 11'(ex + 1023), m[51:0]};
    end
    return o;
  endfunction

  task automatic check_head();
    exp_t x;
    if (q.size() > 0) begin
      x = q.pop_front();
      n_chk++;
      if ({res_o, inexact_o, underflow_o, overflow_o} !== {x.r, x.ix, x.uf, x.ov}) begin
        n_bad++;
        $display("FAIL %s: res=%h ix=%b uf=%b ov=%b expected res=%h ix=%b uf=%b ov=%b",
                 x.tag, res_o, inexact_o, underflow_o, overflow_o, x.r, x.ix, x.uf, x.ov);
      end
    end
  endtask

  // R1: one-cycle latency; each negedge checks the vector of the previous one
  task automatic drive(bit sn, int e, logic [55:0] s, logic [1:0] rm, bit fl, bit tr,
                       exp_t x);
    @(negedge clk);
    check_head();
    sign_i = sn; exp_i = 13'(e); sig_i = s; rmode_i = rm; flush_i = fl; uf_trap_i = tr;
    q.push_back(x);
  endtask

  task automatic dir(bit sn, int e, logic [55:0] s, logic [1:0] rm, bit fl, bit tr,
                     logic [63:0] r, bit ix, bit uf, bit ov, string tag);
    exp_t x;
    x.r = r; x.ix = ix; x.uf = uf; x.ov = ov; x.tag = tag;
    drive(sn, e, s, rm, fl, tr, x);
  endtask

  task automatic mdl(bit sn, int e, logic [55:0] s, logic [1:0] rm, bit fl, bit tr);
    drive(sn, e, s, rm, fl, tr, model(sn, e, s, rm, fl, tr));
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  localparam logic [55:0] ONE  = 56'h80_0000_0000_0000;
  localparam logic [55:0] ALL1 = 56'hFF_FFFF_FFFF_FFFF;

  initial begin
    rst_n = 1'b0; sign_i = 0; exp_i = 0; sig_i = 0; rmode_i = 0; flush_i = 0; uf_trap_i = 0;
    repeat (3) @(negedge clk);
    n_chk++;   // R1 reset state
    if ({res_o, inexact_o, underflow_o, overflow_o} !== 67'd0) begin
      n_bad++;
      $display("FAIL R1: res=%h flags=%b%b%b expected res=0 flags=000",
               res_o, inexact_o, underflow_o, overflow_o);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 exact normal packing
    dir(0, 0, ONE, 0, 0, 0, 64'h3FF0000000000000, 0, 0, 0, "R2");
    dir(1, 1023, 56'hFF_FFFF_FFFF_FFF8, 1, 0, 0, 64'hFFEFFFFFFFFFFFFF, 0, 0, 0, "R2");
    // R3 rounding modes and ties
    dir(0, 0, 56'h80_0000_0000_0004, 0, 0, 0, 64'h3FF0000000000000, 1, 0, 0, "R3");
    dir(0, 0, 56'h80_0000_0000_000C, 0, 0, 0, 64'h3FF0000000000002, 1, 0, 0, "R3");
    dir(0, 0, 56'h80_0000_0000_0001, 2, 0, 0, 64'h3FF0000000000001, 1, 0, 0, "R3");
    dir(1, 0, 56'h80_0000_0000_0001, 2, 0, 0, 64'hBFF0000000000000, 1, 0, 0, "R3");
    dir(1, 0, 56'h80_0000_0000_0001, 3, 0, 0, 64'hBFF0000000000001, 1, 0, 0, "R3");
    dir(0, 0, 56'h80_0000_0000_0007, 1, 0, 0, 64'h3FF0000000000000, 1, 0, 0, "R3");
    // R4 renormalising carry
    dir(0, 5, ALL1, 0, 0, 0, 64'h4050000000000000, 1, 0, 0, "R4");
    // R5 overflow per mode
    dir(0, 1023, ALL1, 0, 0, 0, 64'h7FF0000000000000, 1, 0, 1, "R5");
    dir(0, 1024, ONE, 1, 0, 0, 64'h7FEFFFFFFFFFFFFF, 1, 0, 1, "R5");
    dir(1, 1024, ONE, 2, 0, 0, 64'hFFEFFFFFFFFFFFFF, 1, 0, 1, "R5");
    dir(1, 1024, ONE, 3, 0, 0, 64'hFFF0000000000000, 1, 0, 1, "R5");
    dir(0, 1024, ONE, 3, 0, 0, 64'h7FEFFFFFFFFFFFFF, 1, 0, 1, "R5");
    // R8 flush per mode and sign
    dir(0, -1030, ONE, 2, 1, 0, 64'h0000000000000001, 1, 1, 0, "R8");
    dir(1, -1030, ONE, 2, 1, 0, 64'h8000000000000000, 1, 1, 0, "R8");
    dir(1, -1030, ONE, 3, 1, 0, 64'h8000000000000001, 1, 1, 0, "R8");
    dir(0, -1030, ONE, 3, 1, 0, 64'h0000000000000000, 1, 1, 0, "R8");
    dir(1, -1030, ONE, 0, 1, 0, 64'h8000000000000000, 1, 1, 0, "R8");
    // R7 carry back into normal range at exponent -1023
    dir(0, -1023, ALL1, 0, 0, 1, 64'h0010000000000000, 1, 0, 0, "R7");
    // R9 exact subnormal with and without trap enable
    dir(0, -1023, ONE, 0, 0, 1, 64'h0008000000000000, 0, 1, 0, "R9");
    dir(0, -1023, ONE, 0, 0, 0, 64'h0008000000000000, 0, 0, 0, "R9");
    // R6 sticky shift, clamp and tiny inexact
    dir(0, -2000, ONE, 2, 0, 0, 64'h0000000000000001, 1, 1, 0, "R6");
    dir(0, -2000, ONE, 0, 0, 0, 64'h0000000000000000, 1, 1, 0, "R6");
    dir(0, -1024, ONE, 0, 0, 0, 64'h0004000000000000, 0, 0, 0, "R6");
    dir(0, -1023, 56'h80_0000_0000_0008, 0, 0, 0, 64'h0008000000000000, 1, 1, 0, "R6");

    // model-checked sweep around the boundary exponents, all modes
    for (int i = 0; i < 4000; i++) begin
      int cls, e;
      logic [63:0] rv;
      logic [55:0] s;
      cls = $urandom_range(0, 5);
      case (cls)
        0: e = $urandom_range(0, 70) - 1090;
        1: e = $urandom_range(0, 12) - 1030;
        2: e = $urandom_range(1015, 1030);
        3: e = $urandom_range(0, 3000) - 4000;
        default: e = $urandom_range(0, 2000) - 1000;
      endcase
      rv = {$urandom, $urandom};
      s = {1'b1, rv[54:0]};
      if ($urandom_range(0, 3) == 0) s[54:0] = {55{1'b1}};
      if ($urandom_range(0, 3) == 0) s[2:0] = 3'b100;
      mdl(1'($urandom), e, s, 2'($urandom), 1'($urandom_range(0, 3) == 0),
          1'($urandom));
    end

    @(negedge clk);
    check_head();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end
endmodule